// File: doc/BRIEF.md
# I2C Control Register Target with Stall Watchdog

This block is the host-facing side of a pulsed light-source controller. It is an I2C target that holds eight byte-wide registers. Seven of them can be written: the pulse period (16 bits across two registers), the pulse width, and four DAC codes. The eighth is a read-only status byte built from two flags driven by the DAC sequencer. A host sets a register pointer and then writes data bytes or reads them back with a repeated start. This lets it confirm that every setting arrived intact. The register contents drive the pulse generator and the DAC sequencer continuously. A one-cycle strobe marks each accepted data byte so that downstream logic can start an action such as a DAC update.

Both bus lines pass through a two-stage synchroniser and a persistence filter before START, STOP and clock edges are detected. A watchdog arms once the pointer byte of a command has been acknowledged. If the following data byte has not completed when the watchdog expires, the whole target returns to idle and releases SDA. A single upset cannot then leave the bus held in the middle of a command.

Top module: `pulse_i2c_regs`

## Requirements
- R1: The target acknowledges a 7-bit address equal to DEV_ADDR. For any other address it leaves the ACK bit high and ignores all traffic until the next START.
- R2: A write is the address with R/W=0, then a pointer byte, then data. The pointer's low three bits select the register: 0 = period[7:0], 1 = period[15:8], 2 = width, 3..6 = DAC codes 0..3 (DAC n on dac_codes[8n+7:8n]). The data byte goes into the selected register, and the register's output changes only on a strobe for that index.
- R3: A read sets the pointer with a write, then sends a repeated start and the address with R/W=1. The target returns the selected register first. Each master ACK advances the pointer by one, modulo 8, and a master NACK ends the read.
- R4: Several data bytes in one write go to consecutive registers, starting at the pointer.
- R5: Register 7 reads as {6'b0, dac_busy, dac_err}, with busy in bit 1 and the error flag in bit 0. A write to it is acknowledged but leaves every register unchanged.
- R6: wr_stb is high for exactly one cycle for each completed data byte, including a byte sent to register 7. wr_idx carries that byte's register index.
- R7: After the pointer byte is acknowledged, the target returns to idle if the next data byte has not completed within TIMEOUT_CYC clocks and no START or STOP has arrived. It then releases SDA, does not acknowledge further bytes, issues no strobe and keeps all register contents. A data byte that arrives before the limit is accepted normally.
- R8: After reset all registers read zero, SDA is released and wr_stb is low.
- R9: A pulse on SCL or SDA lasting fewer than FILT_LEN clocks has no effect on a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| dac_err | input | 1 | DAC communication error flag |
| dac_busy | input | 1 | DAC bus busy flag |
| pulse_period | output | 16 | Pulse period setting |
| pulse_width | output | 8 | Pulse width setting |
| dac_codes | output | 32 | Four DAC codes, DAC n in bits 8n+7:8n |
| wr_stb | output | 1 | One-cycle strobe per accepted data byte |
| wr_idx | output | 3 | Register index of the strobed byte |

## Verification
The assertions assume that the bus obeys I2C framing. The master must change SDA only while SCL is low, and it must leave at least a few filter delays between an SCL edge and its own SDA change. Otherwise a data change could be taken as a START or STOP. The bench's bit tasks enforce this by inserting a quarter-bit gap around every SCL edge. Its only out-of-protocol events are deliberate pulses shorter than the filter window. Random register indices and data are mixed with directed cases for address mismatch, pointer wrap into the status register, a stall just past the watchdog limit and a pause well inside it.

// File: rtl/pulse_i2c_regs.sv
module pulse_i2c_regs #(
  parameter logic [6:0] DEV_ADDR    = 7'h3C,
  parameter int         FILT_LEN    = 4,
  parameter int         TIMEOUT_CYC = 4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  input  logic        dac_err,
  input  logic        dac_busy,
  output logic [15:0] pulse_period,
  output logic [7:0]  pulse_width,
  output logic [31:0] dac_codes,
  output logic        wr_stb,
  output logic [2:0]  wr_idx
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_IDX, S_DATA, S_ACK, S_TX, S_TXACK} st_t;

  logic [1:0] raw, filt;
  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    logic q1, q2, f;
    logic [FW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        q1 <= 1'b1; q2 <= 1'b1; f <= 1'b1; cnt <= '0;
      end else begin
        q1 <= raw[g];
        q2 <= q1;
        if (q2 == f) cnt <= '0;
        else if (cnt == FW'(FILT_LEN - 1)) begin f <= q2; cnt <= '0; end
        else cnt <= cnt + 1'b1;
      end
    assign filt[g] = f;
  end

  logic scl_f, sda_f, scl_d, sda_d;
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
    else begin scl_d <= scl_f; sda_d <= sda_f; end

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;

  st_t         state, nxt;
  logic [3:0]  bcnt;
  logic [7:0]  shreg, txbyte;
  logic [2:0]  idx;
  logic        sda_drv, mack, wd_on;
  logic [TW-1:0] wd_cnt;
  logic [7:0]  bank [0:7];

  logic wd_exp;
  assign wd_exp = wd_on && (wd_cnt == TW'(TIMEOUT_CYC - 1));

  function automatic logic [7:0] rd_mux(input logic [2:0] i);
    rd_mux = (i == 3'd7) ? {6'b0, dac_busy, dac_err} : bank[i];
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; nxt <= S_IDLE; bcnt <= '0; shreg <= '0; txbyte <= '0;
      idx <= '0; sda_drv <= 1'b0; mack <= 1'b0; wd_on <= 1'b0; wd_cnt <= '0;
      wr_stb <= 1'b0; wr_idx <= '0;
      for (int k = 0; k < 8; k++) bank[k] <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_ev) begin
        state <= S_ADDR; bcnt <= '0; sda_drv <= 1'b0; wd_on <= 1'b0;
      end else if (stop_ev || wd_exp) begin
        state <= S_IDLE; sda_drv <= 1'b0; wd_on <= 1'b0;
      end else begin
        if (wd_on) wd_cnt <= wd_cnt + 1'b1;
        case (state)
          S_ADDR, S_IDX, S_DATA:
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_f};
              bcnt  <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              case (state)
                S_ADDR:
                  if (shreg[7:1] == DEV_ADDR) begin
                    sda_drv <= 1'b1; state <= S_ACK;
                    nxt <= shreg[0] ? S_TX : S_IDX;
                    txbyte <= rd_mux(idx);
                  end else state <= S_IDLE;
                S_IDX: begin
                  idx <= shreg[2:0]; sda_drv <= 1'b1; state <= S_ACK; nxt <= S_DATA;
                  wd_on <= 1'b1; wd_cnt <= '0;
                end
                default: begin
                  if (idx != 3'd7) bank[idx] <= shreg;
                  wr_stb <= 1'b1; wr_idx <= idx; idx <= idx + 1'b1;
                  sda_drv <= 1'b1; state <= S_ACK; nxt <= S_DATA; wd_on <= 1'b0;
                end
              endcase
            end
          S_ACK:
            if (scl_fall) begin
              state <= nxt; bcnt <= '0;
              sda_drv <= (nxt == S_TX) ? ~txbyte[7] : 1'b0;
            end
          S_TX:
            if (scl_rise) bcnt <= bcnt + 1'b1;
            else if (scl_fall) begin
              if (bcnt == 4'd8) begin sda_drv <= 1'b0; state <= S_TXACK; end
              else sda_drv <= ~txbyte[3'd7 - bcnt[2:0]];
            end
          S_TXACK:
            if (scl_rise) mack <= ~sda_f;
            else if (scl_fall) begin
              if (mack) begin
                idx <= idx + 1'b1; txbyte <= rd_mux(idx + 1'b1);
                sda_drv <= ~rd_mux(idx + 1'b1)[7]; state <= S_TX; bcnt <= '0;
              end else state <= S_IDLE;
            end
          default: ;
        endcase
      end
    end

  assign sda_oe       = sda_drv;
  assign pulse_period = {bank[1], bank[0]};
  assign pulse_width  = bank[2];
  assign dac_codes    = {bank[6], bank[5], bank[4], bank[3]};

  a_r6_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r7_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_exp && !start_ev) |=> (state == S_IDLE && !sda_oe));
  a_r2_width_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pulse_width) |-> (wr_stb && wr_idx == 3'd2));
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
endmodule

// File: tb/test_pulse_i2c_regs.sv
module test_pulse_i2c_regs;
  localparam int CLK_PERIOD = 10;
  localparam int H = 20;
  localparam int Q = 10;
  localparam int TMO = 600;
  localparam logic [6:0] ADR = 7'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic dac_err = 1'b0, dac_busy = 1'b0;
  logic sda_oe, wr_stb;
  logic [2:0] wr_idx;
  logic [15:0] pulse_period;
  logic [7:0] pulse_width;
  logic [31:0] dac_codes;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_i2c_regs #(.DEV_ADDR(ADR), .FILT_LEN(4), .TIMEOUT_CYC(TMO)) i_pulse_i2c_regs (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .dac_err(dac_err), .dac_busy(dac_busy), .pulse_period(pulse_period),
    .pulse_width(pulse_width), .dac_codes(dac_codes), .wr_stb(wr_stb), .wr_idx(wr_idx));

  int checks = 0, fails = 0, stb_cnt = 0;
  logic [2:0] last_idx = '0;
  logic [7:0] model [0:7];
  logic [7:0] rbuf [0:7];
  bit done = 1'b0;

  always @(posedge clk) if (wr_stb) begin stb_cnt++; last_idx = wr_idx; end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_of(input logic [2:0] i);
    exp_of = (i == 3'd7) ? {6'b0, dac_busy, dac_err} : model[i];
  endfunction

  function automatic logic [7:0] port_of(input logic [2:0] i);
    case (i)
      3'd0: port_of = pulse_period[7:0];
      3'd1: port_of = pulse_period[15:8];
      3'd2: port_of = pulse_width;
      3'd7: port_of = 8'h00;
      default: port_of = dac_codes[8*(i-3) +: 8];
    endcase
  endfunction

  task automatic i2c_start; m_sda = 1; m_scl = 1; wt(H); m_sda = 0; wt(H); m_scl = 0; endtask
  task automatic i2c_rstart; wt(Q); m_sda = 1; wt(Q); m_scl = 1; wt(H); m_sda = 0; wt(H); m_scl = 0; endtask
  task automatic i2c_stop; wt(Q); m_sda = 0; wt(Q); m_scl = 1; wt(H); m_sda = 1; wt(H); endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      wt(Q); m_sda = b[i]; wt(4);
      if (glitch && i == 2) begin m_scl = 1; wt(1); m_scl = 0; end else wt(1);
      wt(Q - 5); m_scl = 1; wt(5);
      if (glitch && i == 4) begin m_sda = !m_sda; wt(1); m_sda = !m_sda; end else wt(1);
      wt(H - 6); m_scl = 0;
    end
    wt(Q); m_sda = 1; wt(Q); m_scl = 1; wt(Q); ack = !sda_line; wt(Q); m_scl = 0;
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(2*Q); m_scl = 1; wt(Q); b[i] = sda_line; wt(Q); m_scl = 0;
    end
    wt(Q); m_sda = last; wt(Q); m_scl = 1; wt(H); m_scl = 0; wt(Q); m_sda = 1;
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [7:0] d, input bit glitch, input string req);
    bit a0, a1, a2;
    i2c_start; send_byte({ADR, 1'b0}, 0, a0); send_byte({5'b0, idx}, 0, a1);
    send_byte(d, glitch, a2); i2c_stop;
    chk({req, " R1 acks"}, {a0, a1, a2}, 3'b111);
    if (idx != 3'd7) model[idx] = d;
  endtask

  task automatic rd_regs(input logic [2:0] idx, input int n);
    bit a0, a1, a2;
    logic [7:0] b;
    i2c_start; send_byte({ADR, 1'b0}, 0, a0); send_byte({5'b0, idx}, 0, a1);
    i2c_rstart; send_byte({ADR, 1'b1}, 0, a2);
    for (int k = 0; k < n; k++) begin recv_byte(k == n - 1, b); rbuf[k] = b; end
    i2c_stop;
    chk("R3 read acks", {a0, a1, a2}, 3'b111);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a0, a1, a2;
    int s0;
    void'($urandom(32'd4242));
    for (int k = 0; k < 8; k++) model[k] = '0;
    wt(5);
    chk("R8 period reset", pulse_period, 0);
    chk("R8 width reset", pulse_width, 0);
    chk("R8 dac reset", dac_codes, 0);
    chk("R8 sda released", {sda_oe, wr_stb}, 0);
    rst_n = 1; wt(10);

    s0 = stb_cnt;
    wr_reg(3'd2, 8'h5A, 0, "R2 width");
    chk("R2 width value", pulse_width, 8'h5A);
    chk("R6 one strobe", stb_cnt - s0, 1);
    chk("R6 strobe idx", last_idx, 2);

    s0 = stb_cnt;
    i2c_start; send_byte({ADR, 1'b0}, 0, a0); send_byte(8'h00, 0, a1);
    send_byte(8'h34, 0, a2); send_byte(8'h12, 0, a0); i2c_stop;
    model[0] = 8'h34; model[1] = 8'h12;
    chk("R4 period burst", pulse_period, 16'h1234);
    chk("R6 burst strobes", stb_cnt - s0, 2);
    chk("R6 burst last idx", last_idx, 1);

    for (int n = 0; n < 12; n++) begin
      logic [2:0] ri;
      logic [7:0] rd;
      ri = 3'($urandom_range(0, 6));
      rd = 8'($urandom);
      wr_reg(ri, rd, 0, "R2 random");
      chk("R2 random port", port_of(ri), rd);
    end
    for (int n = 0; n < 4; n++) begin
      logic [2:0] ri;
      ri = 3'($urandom_range(0, 6));
      rd_regs(ri, 3);
      for (int k = 0; k < 3; k++) chk("R3 readback", rbuf[k], exp_of(3'(ri + k)));
    end

    dac_err = 1; dac_busy = 0;
    rd_regs(3'd7, 1);
    chk("R5 status err", rbuf[0], 8'h01);
    dac_busy = 1;
    s0 = stb_cnt;
    wr_reg(3'd7, 8'hFF, 0, "R5 status write");
    chk("R6 strobe on status", last_idx, 7);
    chk("R6 status strobe count", stb_cnt - s0, 1);
    rd_regs(3'd6, 3);
    chk("R3 wrap into status", rbuf[1], 8'h03);
    chk("R5 status ignored", rbuf[1], 8'h03);
    chk("R3 wrap to reg0", rbuf[2], model[0]);
    chk("R5 reg6 unchanged", rbuf[0], model[6]);

    s0 = stb_cnt;
    i2c_start; send_byte({7'h2A, 1'b0}, 0, a0); send_byte(8'h02, 0, a1);
    send_byte(8'hEE, 0, a2); i2c_stop;
    chk("R1 mismatch nack", {a0, a1, a2}, 3'b000);
    chk("R1 mismatch no write", {pulse_width, 8'(stb_cnt - s0)}, {model[2], 8'h00});

    s0 = stb_cnt;
    i2c_start; send_byte({ADR, 1'b0}, 0, a0); send_byte(8'h03, 0, a1);
    wt(TMO + 100);
    send_byte(8'hC3, 0, a2); i2c_stop;
    chk("R7 timeout nack", {a0, a1, a2}, 3'b110);
    chk("R7 timeout keeps dac0", dac_codes[7:0], model[3]);
    chk("R7 timeout no strobe", stb_cnt - s0, 0);
    wr_reg(3'd3, 8'hC3, 0, "R7 after timeout");
    chk("R7 recovery write", dac_codes[7:0], 8'hC3);

    i2c_start; send_byte({ADR, 1'b0}, 0, a0); send_byte(8'h04, 0, a1);
    wt(100);
    send_byte(8'h96, 0, a2); i2c_stop;
    chk("R7 pause inside limit", {a0, a1, a2}, 3'b111);
    model[4] = 8'h96;
    chk("R7 pause data stored", dac_codes[15:8], 8'h96);

    s0 = stb_cnt;
    wr_reg(3'd2, 8'hA5, 1, "R9 glitch");
    chk("R9 glitch value", pulse_width, 8'hA5);
    chk("R9 glitch one strobe", stb_cnt - s0, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule